// File: doc/BRIEF.md
# Logical Port Remap Table

This block translates an 8-bit logical port number, as carried on an incoming packet interface, into a 6-bit internal identifier. It also picks one of four downstream processing engines for that port. The table has one entry per port, 256 in all, and each entry sits at the address equal to its port number. Every entry holds a 6-bit identifier, a 2-bit engine code and an enable bit. Software fills the table through a small register bus made of address, write data, write enable and read data. The datapath presents a port number with a valid strobe and gets the result one clock later.

A port whose enable bit is clear is not dropped. Its traffic is still given a defined mapping: identifier zero, engine code zero, with the enabled flag low, so that downstream logic can tell the fallback apart from a real hit. After reset every entry is zero, so every port starts disabled.

The result path is a two-state machine. `LK_IDLE` means no result is being presented. `LK_SHOW` means the result of last cycle's lookup is on the outputs. The transition `IDLE_TO_SHOW` is taken when the lookup strobe is high. `SHOW_TO_SHOW` is taken when another lookup follows directly. `SHOW_TO_IDLE` is taken when the strobe is low.

Top module: `lp_remap_table`

## Requirements
- R1: After reset every entry reads as 0, and a lookup of any port returns identifier 0, engine code 0 and enabled flag 0.
- R2: A host write stores write-data bits 5:0 as the identifier, bits 7:6 as the engine code and bit 8 as the enable. The read data in the cycle after an address is presented holds that entry in the same bit positions.
- R3: Write-data bits 15:9 are discarded, and read-data bits 15:9 are always 0.
- R4: `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high. While `res_valid` is low, the identifier, the engine code, the one-hot engine select and the enabled flag are all 0.
- R5: A lookup of an enabled entry returns the stored identifier and engine code, with the enabled flag set to 1.
- R6: A lookup of a disabled entry returns identifier 0, engine code 0, an all-zero one-hot select and enabled flag 0, whatever the entry's identifier and engine fields hold.
- R7: If a host write and a lookup (or a host read) address the same entry in the same cycle, the result carries the entry's old contents. The new value is seen from the next cycle on.
- R8: On an enabled result, engine codes 0, 1, 2 and 3 (engines A, B, C, D) set exactly bit 0, 1, 2 or 3 of `res_eng_onehot`.
- R9: A write changes only the entry at its address. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Entry index for a host read or write |
| host_wdata | input | 16 | Host write data |
| host_we | input | 1 | Host write enable |
| host_rdata | output | 16 | Entry at last cycle's `host_addr`, zero-extended |
| lk_valid | input | 1 | Lookup strobe |
| lk_port | input | 8 | Port number to look up |
| res_valid | output | 1 | Lookup result valid |
| res_lid | output | 6 | Mapped identifier |
| res_eng | output | 2 | Engine code |
| res_eng_onehot | output | 4 | One-hot engine select |
| res_enabled | output | 1 | Entry was enabled |

## Verification
Lookups are tried in three patterns: back-to-back, with gaps between strobes, and with a write to the same entry in the same cycle. Back-to-back versus gapped lookups shows whether the result state machine follows the strobe or sticks in `LK_SHOW`. The same-cycle write shows whether the lookup sees the old or the new contents. Entries are written with the enable set and cleared, with every engine code, and with junk in the upper write bits. This separates the real-hit path from the zero fallback and tests the bit positions of each field. A full random program of all 256 entries, followed by random reads and lookups, catches address decode faults that would spill one write onto a neighbour.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 1 << PORT_W;
    localparam int LID_W     = 6;
    localparam int ENG_W     = 2;
    localparam int NUM_ENG   = 1 << ENG_W;
    localparam int ENTRY_W   = LID_W + ENG_W + 1;
    localparam int BUS_W     = 16;

    typedef struct packed {
        logic             en;
        logic [ENG_W-1:0] eng;
        logic [LID_W-1:0] lid;
    } lpr_entry_t;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_SHOW = 1'b1
    } lk_state_t;
endpackage

// File: rtl/lpr_entry_store.sv
module lpr_entry_store
    import lpr_pkg::*;
#(
    parameter int IDX_W = PORT_W,
    parameter int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  lpr_entry_t       wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output lpr_entry_t       rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output lpr_entry_t       rd_b_data
);
    lpr_entry_t cells [DEPTH];

    // one register per entry, reset to all-zero (disabled, identifier 0, engine A)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    cells[i] <= wr_data;
                end
            end
        end
    end

    // reads see the contents before any write in the same cycle
    assign rd_a_data = cells[rd_a_idx];
    assign rd_b_data = cells[rd_b_idx];
endmodule

// File: rtl/lpr_host_port.sv
module lpr_host_port
    import lpr_pkg::*;
#(
    parameter int DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    output lpr_entry_t        wr_entry,
    input  lpr_entry_t        rd_entry,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - ENTRY_W;

    // only the defined field bits reach the table
    assign wr_entry = lpr_entry_t'(wdata[ENTRY_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= {{PAD_W{1'b0}}, rd_entry};
        end
    end
endmodule

// File: rtl/lpr_lookup_fsm.sv
module lpr_lookup_fsm
    import lpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  lpr_entry_t         lk_entry,
    output logic               res_valid,
    output logic [LID_W-1:0]   res_lid,
    output logic [ENG_W-1:0]   res_eng,
    output logic [NUM_ENG-1:0] res_eng_onehot,
    output logic               res_enabled
);
    lk_state_t state_q, state_d;

    logic [LID_W-1:0]   lid_d;
    logic [ENG_W-1:0]   eng_d;
    logic [NUM_ENG-1:0] oh_d;
    logic               en_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: if (lk_valid)  state_d = LK_SHOW;   // IDLE_TO_SHOW
            LK_SHOW: if (!lk_valid) state_d = LK_IDLE;   // SHOW_TO_IDLE, else SHOW_TO_SHOW
            default: state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // a disabled entry falls back to identifier 0 on engine A
    assign en_d  = lk_valid && lk_entry.en;
    assign lid_d = en_d ? lk_entry.lid : '0;
    assign eng_d = en_d ? lk_entry.eng : '0;

    generate
        for (genvar k = 0; k < NUM_ENG; k++) begin : g_oh
            assign oh_d[k] = en_d && (lk_entry.eng == ENG_W'(k));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_lid        <= '0;
            res_eng        <= '0;
            res_eng_onehot <= '0;
            res_enabled    <= 1'b0;
        end else begin
            res_lid        <= lid_d;
            res_eng        <= eng_d;
            res_eng_onehot <= oh_d;
            res_enabled    <= en_d;
        end
    end

    assign res_valid = (state_q == LK_SHOW);
endmodule

// File: rtl/lp_remap_table.sv
module lp_remap_table
    import lpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORT_W-1:0]  host_addr,
    input  logic [BUS_W-1:0]   host_wdata,
    input  logic               host_we,
    output logic [BUS_W-1:0]   host_rdata,
    input  logic               lk_valid,
    input  logic [PORT_W-1:0]  lk_port,
    output logic               res_valid,
    output logic [LID_W-1:0]   res_lid,
    output logic [ENG_W-1:0]   res_eng,
    output logic [NUM_ENG-1:0] res_eng_onehot,
    output logic               res_enabled
);
    lpr_entry_t wr_entry, host_entry, lk_entry;

    lpr_host_port #(.DATA_W(BUS_W)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (host_wdata),
        .wr_entry (wr_entry),
        .rd_entry (host_entry),
        .rdata    (host_rdata)
    );

    lpr_entry_store #(.IDX_W(PORT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_we),
        .wr_idx    (host_addr),
        .wr_data   (wr_entry),
        .rd_a_idx  (host_addr),
        .rd_a_data (host_entry),
        .rd_b_idx  (lk_port),
        .rd_b_data (lk_entry)
    );

    lpr_lookup_fsm u_lookup (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_valid       (lk_valid),
        .lk_entry       (lk_entry),
        .res_valid      (res_valid),
        .res_lid        (res_lid),
        .res_eng        (res_eng),
        .res_eng_onehot (res_eng_onehot),
        .res_enabled    (res_enabled)
    );
endmodule

// File: rtl/lpr_checker.sv
module lpr_checker
    import lpr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [BUS_W-1:0]   host_rdata,
    input logic               res_valid,
    input logic [LID_W-1:0]   res_lid,
    input logic [ENG_W-1:0]   res_eng,
    input logic [NUM_ENG-1:0] res_eng_onehot,
    input logic               res_enabled
);
    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_valid_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_lid == '0 && res_eng == '0 && res_eng_onehot == '0 && !res_enabled));

    assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_enabled) |-> (res_lid == '0 && res_eng == '0 && res_eng_onehot == '0));

    assert_onehot_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_enabled |-> ($countones(res_eng_onehot) == 1 && res_eng_onehot[res_eng]));

    assert_rdata_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[BUS_W-1:ENTRY_W] == '0);
endmodule

bind lp_remap_table lpr_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .host_rdata     (host_rdata),
    .res_valid      (res_valid),
    .res_lid        (res_lid),
    .res_eng        (res_eng),
    .res_eng_onehot (res_eng_onehot),
    .res_enabled    (res_enabled)
);

// File: tb/lp_remap_table_tb.sv
module lp_remap_table_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_we = 1'b0;
    logic [15:0] host_rdata;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_port = '0;
    logic        res_valid;
    logic [5:0]  res_lid;
    logic [1:0]  res_eng;
    logic [3:0]  res_eng_onehot;
    logic        res_enabled;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    lp_remap_table u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .lk_valid(lk_valid), .lk_port(lk_port),
        .res_valid(res_valid), .res_lid(res_lid), .res_eng(res_eng),
        .res_eng_onehot(res_eng_onehot), .res_enabled(res_enabled)
    );

    // behavioural reference: plain integer table, updated at each edge
    int mm [256];
    int e_rdata, e_lid, e_eng, e_oh, e_en, e_valid;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mm[i]) mm[i] = 0;
            e_rdata = 0; e_lid = 0; e_eng = 0; e_oh = 0; e_en = 0; e_valid = 0;
        end else begin
            int ent;
            e_rdata = mm[host_addr];
            e_valid = lk_valid ? 1 : 0;
            ent = mm[lk_port];
            if (lk_valid && ent >= 256) begin
                e_en = 1; e_lid = ent % 64; e_eng = (ent / 64) % 4; e_oh = 1 << e_eng;
            end else begin
                e_en = 0; e_lid = 0; e_eng = 0; e_oh = 0;
            end
            if (host_we) mm[host_addr] = host_wdata % 512;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(host_rdata == 16'(e_rdata), cur_req, "host_rdata", host_rdata, e_rdata);
            check(res_valid == 1'(e_valid), "R4", "res_valid", res_valid, e_valid);
            check(res_lid == 6'(e_lid), cur_req, "res_lid", res_lid, e_lid);
            check(res_eng == 2'(e_eng), cur_req, "res_eng", res_eng, e_eng);
            check(res_eng_onehot == 4'(e_oh), cur_req, "res_eng_onehot", res_eng_onehot, e_oh);
            check(res_enabled == 1'(e_en), cur_req, "res_enabled", res_enabled, e_en);
        end
    end

    task automatic cyc(input bit we, input int addr, input int wd, input bit lv, input int lp);
        @(posedge clk);
        #1;
        host_we = we; host_addr = 8'(addr); host_wdata = 16'(wd);
        lk_valid = lv; lk_port = 8'(lp);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: everything zero after reset
        cur_req = "R1";
        for (int p = 0; p < 256; p++) cyc(0, p, 0, 1, 255 - p);
        idle();
        // R2: field placement on write and read back
        cur_req = "R2";
        cyc(1, 10, 9'h1_2A, 0, 0);
        cyc(1, 11, 9'h0_C5, 0, 0);
        cyc(0, 10, 0, 0, 0);
        cyc(0, 11, 0, 0, 0);
        idle();
        // R3: upper write bits dropped
        cur_req = "R3";
        cyc(1, 12, 16'hFE00 | 9'h1_7F, 0, 0);
        cyc(0, 12, 0, 1, 12);
        idle();
        // R5 and R8: enabled entries with each engine code
        cur_req = "R8";
        for (int k = 0; k < 4; k++) cyc(1, 20 + k, 256 | (k << 6) | (k * 9 + 3), 0, 0);
        cur_req = "R5";
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 20 + k);
        idle();
        // R6: disabled entries with nonzero fields fall back to zero
        cur_req = "R6";
        cyc(1, 30, 9'h0_FF, 0, 0);
        cyc(1, 31, 9'h0_81, 1, 30);
        cyc(0, 31, 0, 1, 31);
        idle();
        // R4: gapped strobes
        cur_req = "R4";
        cyc(0, 0, 0, 1, 20); idle(); cyc(0, 0, 0, 1, 21); idle(); idle(); cyc(0, 0, 0, 1, 22); idle();
        // R7: same-cycle write and lookup of one entry
        cur_req = "R7";
        cyc(1, 40, 9'h1_55, 1, 40);
        cyc(0, 40, 0, 1, 40);
        cyc(1, 40, 9'h0_11, 1, 40);
        cyc(0, 40, 0, 1, 40);
        idle();
        // R9: random program of all entries, then random reads and lookups
        cur_req = "R9";
        for (int p = 0; p < 256; p++) cyc(1, p, int'($urandom_range(0, 65535)), 0, 0);
        for (int n = 0; n < 600; n++)
            cyc(($urandom_range(0, 7) == 0), int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
                ($urandom_range(0, 3) != 0), int'($urandom_range(0, 255)));
        idle();
        idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule